// File: doc/BRIEF.md
# DRAM Bank Timing and Row-State Tracker

This block follows one DRAM bank that runs an open-row policy. It remembers whether a row sits in the bank's row buffer and, if so, which row it is. It keeps one timing window for each of the four bank commands: precharge, activate, read and write. From these it raises a ready flag for each command type whenever that command would respect this bank's own spacing rules. Any earlier command can load a window. A later command may lengthen a window but never shorten it. Rank, bus, refresh and power-down timing lie outside this block, and no auto-precharge form exists.

A scheduler reports each command it places on the bank through a one-cycle issue strobe, with an opcode and a row. A command strobed while its ready flag is low is an error. The block flags it in the same cycle and drops it. The strobe is fire-and-forget: there is no back-pressure, and the error flag is the only response.

A second, purely combinational query port takes a pending request's row and direction. It reports whether the request hits the open row, which command the request needs next, and whether that command may go now. Default timing uses DDR3-1333 values in clock cycles: CL 9, WL 7, burst of 8 (4 clocks of data), tRP 9, tRCD 9, tWR 10, tWTR 5.

Top module: `bank_tracker`

## Requirements
- R1: After reset no row is open, `rdy_act` is 1, and `rdy_pre`, `rdy_rd` and `rdy_wr` are 0.
- R2: An accepted activate (`cmd_op` code 1) opens the row: in the next cycle `row_open` is 1 and `open_row` equals the strobed `cmd_row`.
- R3: An accepted precharge (code 0) closes the row in the next cycle. Activate becomes ready so that the earliest legal activate lands tRP (9) cycles after the precharge.
- R4: After an activate, the earliest read or write lands tRCD (9) cycles later. A precharge may follow an activate on the very next cycle.
- R5: After a write, the earliest precharge lands WL + BL/2 + tWR (21) cycles later.
- R6: Two column commands in the same direction are spaced by at least BL/2 (4) cycles.
- R7: Direction turnaround: the earliest read after a write lands WL + BL/2 + tWTR (16) cycles later. The earliest write after a read lands CL + BL/2 + 2 - WL (8) cycles later.
- R8: After a read, the earliest precharge lands BL/2 (4) cycles later.
- R9: `cmd_op` codes are 0 precharge, 1 activate, 2 read, 3 write. A strobed command whose ready flag is low raises `cmd_err` in the same cycle. This covers precharge with no open row, activate while a row is open, a column command with no open row, and any command inside its window. Such a command changes neither the row state nor any timing window.
- R10: Query behaviour:
  - When the open row equals `qry_row`, `qry_hit` is 1 and `qry_next` is 2 for a read or 3 for a write (`qry_wr` = 1 means write).
  - When a different row is open, `qry_next` is 0 (precharge).
  - When no row is open, `qry_next` is 1 (activate).
  - In every case `qry_go` equals the ready flag of the command named by `qry_next`.
- R11: Windows from several commands overlap without shortening. After a write followed at the earliest legal point by a read, the precharge still waits out the write's 21-cycle recovery, which falls 5 cycles after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | One-cycle strobe: a command is placed on the bank |
| cmd_op | input | 2 | Opcode of the strobed command (0 PRE, 1 ACT, 2 RD, 3 WR) |
| cmd_row | input | ROW_W | Row for an activate; ignored for other opcodes |
| qry_row | input | ROW_W | Row of the pending request being classified |
| qry_wr | input | 1 | Direction of the pending request: 1 write, 0 read |
| rdy_pre | output | 1 | Precharge is legal this cycle |
| rdy_act | output | 1 | Activate is legal this cycle |
| rdy_rd | output | 1 | Read is legal this cycle |
| rdy_wr | output | 1 | Write is legal this cycle |
| row_open | output | 1 | A row is held in the row buffer |
| open_row | output | ROW_W | Index of the held row (meaningful while `row_open` is 1) |
| cmd_err | output | 1 | The strobed command is illegal and is dropped |
| qry_hit | output | 1 | The query row equals the open row |
| qry_next | output | 2 | Next command the pending request needs |
| qry_go | output | 1 | That next command is legal this cycle |

## Verification
The bound checker watches several rules on every cycle:
- activate is never ready while a row is open;
- a dropped command leaves the row state untouched;
- an accepted activate or precharge moves `row_open` and `open_row` as required;
- column commands are blocked on the cycle after an activate;
- precharge never turns ready before the write-recovery span has elapsed, tracked by a cycle counter.

The exact spacing values can only be shown by the bench's scenarios, which measure how many cycles pass before each ready flag rises. These scenarios cover turnaround in both directions, the overlap of a write's recovery with a later read, and the check that a dropped command leaves every pending window as it was.

// File: rtl/bank_cmd_pkg.sv
package bank_cmd_pkg;

  typedef enum logic [1:0] {
    OP_PRE = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } bank_op_e;

  localparam int NUM_OPS = 4;
  localparam int IX_PRE  = 0;
  localparam int IX_ACT  = 1;
  localparam int IX_RD   = 2;
  localparam int IX_WR   = 3;

endpackage

// File: rtl/bank_window_timer.sv
// Saturating down-counter guarding one command type. A load only ever
// extends the remaining window.
module bank_window_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_dec;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_dec = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    cnt_d   = cnt_dec;
    if (load_en && (load_val > cnt_dec)) begin
      cnt_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/bank_load_map.sv
// Translates an accepted command into window loads for the four timers.
// A gap G (cycles between two accepted commands) loads G-1.
module bank_load_map
  import bank_cmd_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int T_RP  = 9,
  parameter int T_RCD = 9,
  parameter int CL    = 9,
  parameter int WL    = 7,
  parameter int BL    = 8,
  parameter int T_WR  = 10,
  parameter int T_WTR = 5,
  parameter int T_RTP = 4
) (
  input  logic                          accept,
  input  logic [1:0]                    op,
  output logic [NUM_OPS-1:0]            load_en,
  output logic [NUM_OPS-1:0][CNT_W-1:0] load_val
);

  localparam int G_PRE_ACT = T_RP;
  localparam int G_ACT_COL = T_RCD;
  localparam int G_SAME    = BL / 2;
  localparam int G_RD_WR   = CL + BL / 2 + 2 - WL;
  localparam int G_WR_RD   = WL + BL / 2 + T_WTR;
  localparam int G_RD_PRE  = T_RTP;
  localparam int G_WR_PRE  = WL + BL / 2 + T_WR;

  function automatic logic [CNT_W-1:0] span(input int gap);
    return (gap > 1) ? CNT_W'(gap - 1) : '0;
  endfunction

  always_comb begin
    load_en  = '0;
    load_val = '0;
    if (accept) begin
      case (bank_op_e'(op))
        OP_PRE: begin
          load_en[IX_ACT]  = 1'b1;
          load_val[IX_ACT] = span(G_PRE_ACT);
        end
        OP_ACT: begin
          load_en[IX_RD]   = 1'b1;
          load_val[IX_RD]  = span(G_ACT_COL);
          load_en[IX_WR]   = 1'b1;
          load_val[IX_WR]  = span(G_ACT_COL);
        end
        OP_RD: begin
          load_en[IX_RD]   = 1'b1;
          load_val[IX_RD]  = span(G_SAME);
          load_en[IX_WR]   = 1'b1;
          load_val[IX_WR]  = span(G_RD_WR);
          load_en[IX_PRE]  = 1'b1;
          load_val[IX_PRE] = span(G_RD_PRE);
        end
        default: begin
          load_en[IX_WR]   = 1'b1;
          load_val[IX_WR]  = span(G_SAME);
          load_en[IX_RD]   = 1'b1;
          load_val[IX_RD]  = span(G_WR_RD);
          load_en[IX_PRE]  = 1'b1;
          load_val[IX_PRE] = span(G_WR_PRE);
        end
      endcase
    end
  end

endmodule

// File: rtl/bank_row_state.sv
module bank_row_state
  import bank_cmd_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [1:0]       op,
  input  logic [ROW_W-1:0] row,
  output logic             row_open,
  output logic [ROW_W-1:0] open_row
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      open_row <= '0;
    end else if (accept) begin
      if (bank_op_e'(op) == OP_ACT) begin
        row_open <= 1'b1;
        open_row <= row;
      end else if (bank_op_e'(op) == OP_PRE) begin
        row_open <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bank_query.sv
module bank_query
  import bank_cmd_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic               row_open,
  input  logic [ROW_W-1:0]   open_row,
  input  logic [ROW_W-1:0]   qry_row,
  input  logic               qry_wr,
  input  logic [NUM_OPS-1:0] ready,
  output logic               qry_hit,
  output logic [1:0]         qry_next,
  output logic               qry_go
);

  always_comb begin
    qry_hit = row_open && (qry_row == open_row);
    if (!row_open) begin
      qry_next = OP_ACT;
    end else if (qry_hit) begin
      qry_next = qry_wr ? OP_WR : OP_RD;
    end else begin
      qry_next = OP_PRE;
    end
    qry_go = ready[qry_next];
  end

endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
  import bank_cmd_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int T_RP  = 9,
  parameter int T_RCD = 9,
  parameter int CL    = 9,
  parameter int WL    = 7,
  parameter int BL    = 8,
  parameter int T_WR  = 10,
  parameter int T_WTR = 5,
  parameter int T_RTP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_vld,
  input  logic [1:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [ROW_W-1:0] qry_row,
  input  logic             qry_wr,
  output logic             rdy_pre,
  output logic             rdy_act,
  output logic             rdy_rd,
  output logic             rdy_wr,
  output logic             row_open,
  output logic [ROW_W-1:0] open_row,
  output logic             cmd_err,
  output logic             qry_hit,
  output logic [1:0]       qry_next,
  output logic             qry_go
);

  localparam int CNT_W =
    $clog2(WL + BL + T_WR + T_WTR + T_RP + T_RCD + CL + T_RTP + 2);

  logic [NUM_OPS-1:0]            expired;
  logic [NUM_OPS-1:0]            ready;
  logic [NUM_OPS-1:0]            load_en;
  logic [NUM_OPS-1:0][CNT_W-1:0] load_val;
  logic                          accept;

  always_comb begin
    ready[IX_PRE] = row_open  && expired[IX_PRE];
    ready[IX_ACT] = !row_open && expired[IX_ACT];
    ready[IX_RD]  = row_open  && expired[IX_RD];
    ready[IX_WR]  = row_open  && expired[IX_WR];
  end

  assign cmd_err = cmd_vld && !ready[cmd_op];
  assign accept  = cmd_vld && !ready[cmd_op] == 1'b0;

  assign rdy_pre = ready[IX_PRE];
  assign rdy_act = ready[IX_ACT];
  assign rdy_rd  = ready[IX_RD];
  assign rdy_wr  = ready[IX_WR];

  bank_load_map #(
    .CNT_W(CNT_W), .T_RP(T_RP), .T_RCD(T_RCD), .CL(CL), .WL(WL),
    .BL(BL), .T_WR(T_WR), .T_WTR(T_WTR), .T_RTP(T_RTP)
  ) u_load (
    .accept   (accept),
    .op       (cmd_op),
    .load_en  (load_en),
    .load_val (load_val)
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_win
    bank_window_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en[g]),
      .load_val (load_val[g]),
      .expired  (expired[g])
    );
  end

  bank_row_state #(.ROW_W(ROW_W)) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .op       (cmd_op),
    .row      (cmd_row),
    .row_open (row_open),
    .open_row (open_row)
  );

  bank_query #(.ROW_W(ROW_W)) u_qry (
    .row_open (row_open),
    .open_row (open_row),
    .qry_row  (qry_row),
    .qry_wr   (qry_wr),
    .ready    (ready),
    .qry_hit  (qry_hit),
    .qry_next (qry_next),
    .qry_go   (qry_go)
  );

endmodule

// File: rtl/bank_tracker_chk.sv
module bank_tracker_chk #(
  parameter int ROW_W = 14,
  parameter int T_RP  = 9,
  parameter int T_RCD = 9,
  parameter int CL    = 9,
  parameter int WL    = 7,
  parameter int BL    = 8,
  parameter int T_WR  = 10,
  parameter int T_WTR = 5,
  parameter int T_RTP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_vld,
  input logic [1:0]       cmd_op,
  input logic [ROW_W-1:0] cmd_row,
  input logic             rdy_pre,
  input logic             rdy_act,
  input logic             rdy_rd,
  input logic             rdy_wr,
  input logic             row_open,
  input logic [ROW_W-1:0] open_row,
  input logic             cmd_err,
  input logic [1:0]       qry_next
);

  localparam int WR_PRE_GAP = WL + BL / 2 + T_WR;

  logic       acc;
  logic [7:0] wr_age;

  assign acc = cmd_vld && !cmd_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_age <= 8'hFF;
    end else if (acc && cmd_op == 2'd3) begin
      wr_age <= 8'd0;
    end else if (wr_age != 8'hFF) begin
      wr_age <= wr_age + 8'd1;
    end
  end

  // R1
  act_closed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_open && rdy_act));

  // R2
  act_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd1) |=> (row_open && open_row == $past(cmd_row)));

  // R3
  pre_closes_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd0) |=> (!row_open && !rdy_act));

  // R4
  act_blocks_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd1) |=> (!rdy_rd && !rdy_wr));

  // R5
  wr_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pre |-> (wr_age >= 8'(WR_PRE_GAP - 1)));

  // R9
  err_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_err) |=> ($stable(row_open) && $stable(open_row)));

  // R10
  qry_closed_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_open |-> (qry_next == 2'd1));

endmodule

bind bank_tracker bank_tracker_chk #(
  .ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD), .CL(CL), .WL(WL),
  .BL(BL), .T_WR(T_WR), .T_WTR(T_WTR), .T_RTP(T_RTP)
) u_chk (.*);

// File: tb/tb_bank_tracker.sv
module tb_bank_tracker;

  localparam int ROW_W = 14;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_vld = 1'b0;
  logic [1:0]       cmd_op = 2'd0;
  logic [ROW_W-1:0] cmd_row = '0;
  logic [ROW_W-1:0] qry_row = '0;
  logic             qry_wr = 1'b0;
  logic             rdy_pre, rdy_act, rdy_rd, rdy_wr;
  logic             row_open;
  logic [ROW_W-1:0] open_row;
  logic             cmd_err;
  logic             qry_hit;
  logic [1:0]       qry_next;
  logic             qry_go;

  always #2.5 clk = ~clk;

  bank_tracker #(.ROW_W(ROW_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .qry_row(qry_row), .qry_wr(qry_wr),
    .rdy_pre(rdy_pre), .rdy_act(rdy_act), .rdy_rd(rdy_rd), .rdy_wr(rdy_wr),
    .row_open(row_open), .open_row(open_row), .cmd_err(cmd_err),
    .qry_hit(qry_hit), .qry_next(qry_next), .qry_go(qry_go)
  );

  typedef struct {
    string req;
    int    idx;
    int    gap;
  } exp_t;

  exp_t sbq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic last_err = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input int row);
    @(negedge clk);
    cmd_vld = 1'b1;
    cmd_op  = op[1:0];
    cmd_row = row[ROW_W-1:0];
    #1;
    last_err = cmd_err;
    @(posedge clk);
    #1;
    cmd_vld = 1'b0;
  endtask

  task automatic issue_when_ready(input int op, input int row);
    logic [3:0] r;
    r = {rdy_wr, rdy_rd, rdy_act, rdy_pre};
    while (!r[op]) begin
      @(posedge clk);
      #1;
      r = {rdy_wr, rdy_rd, rdy_act, rdy_pre};
    end
    issue(op, row);
  endtask

  // Driver side: expected gap (index 0 PRE, 1 ACT, 2 RD, 3 WR).
  task automatic expect_gap(input string req, input int idx, input int gap);
    sbq.push_back('{req, idx, gap});
  endtask

  // Monitor side: measures first-ready gap per command type, then pops.
  task automatic monitor_gaps();
    int first[4];
    for (int i = 0; i < 4; i++) first[i] = -1;
    for (int k = 0; k < 40; k++) begin
      logic [3:0] r;
      r = {rdy_wr, rdy_rd, rdy_act, rdy_pre};
      for (int i = 0; i < 4; i++) begin
        if (first[i] < 0 && r[i]) first[i] = k + 1;
      end
      @(posedge clk);
      #1;
    end
    while (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(e.req, first[e.idx], e.gap);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 row_open", row_open, 0);
    chk("R1 rdy_act", rdy_act, 1);
    chk("R1 rdy_pre", rdy_pre, 0);
    chk("R1 rdy_rd", rdy_rd, 0);
    chk("R1 rdy_wr", rdy_wr, 0);

    // R9 precharge with no open row, read with no open row
    issue(0, 0);
    chk("R9 pre closed err", last_err, 1);
    chk("R9 pre closed row_open", row_open, 0);
    issue(2, 0);
    chk("R9 rd closed err", last_err, 1);

    // R2 / R4 activate row 5
    issue(1, 5);
    chk("R2 act err", last_err, 0);
    chk("R2 row_open", row_open, 1);
    chk("R2 open_row", open_row, 5);
    expect_gap("R4 act->rd", 2, 9);
    expect_gap("R4 act->wr", 3, 9);
    expect_gap("R4 act->pre", 0, 1);
    monitor_gaps();

    // R10 queries with row 5 open and all windows expired
    qry_row = 5; qry_wr = 1'b0; #1;
    chk("R10 hit flag", qry_hit, 1);
    chk("R10 hit read next", qry_next, 2);
    chk("R10 hit go", qry_go, 1);
    qry_wr = 1'b1; #1;
    chk("R10 hit write next", qry_next, 3);
    qry_row = 6; #1;
    chk("R10 conflict hit flag", qry_hit, 0);
    chk("R10 conflict next", qry_next, 0);
    chk("R10 conflict go", qry_go, 1);

    // R9 activate while open is dropped
    issue(1, 9);
    chk("R9 act open err", last_err, 1);
    chk("R9 act open row kept", open_row, 5);

    // R6 / R7 / R8 read spacing
    issue(2, 5);
    chk("R8 rd err", last_err, 0);
    expect_gap("R6 rd->rd", 2, 4);
    expect_gap("R7 rd->wr", 3, 8);
    expect_gap("R8 rd->pre", 0, 4);
    monitor_gaps();

    // R5 / R6 / R7 write spacing
    issue(3, 5);
    chk("R5 wr err", last_err, 0);
    expect_gap("R6 wr->wr", 3, 4);
    expect_gap("R7 wr->rd", 2, 16);
    expect_gap("R5 wr->pre", 0, 21);
    monitor_gaps();

    // R11 write then earliest read: precharge still held by write recovery
    issue(3, 5);
    issue_when_ready(2, 5);
    chk("R11 rd err", last_err, 0);
    expect_gap("R11 rd->pre after wr", 0, 5);
    monitor_gaps();

    // R3 precharge closes, activate waits tRP
    issue(0, 0);
    chk("R3 pre err", last_err, 0);
    chk("R3 row_open", row_open, 0);
    qry_row = 5; qry_wr = 1'b0; #1;
    chk("R10 closed next", qry_next, 1);
    chk("R10 closed go early", qry_go, 0);
    expect_gap("R3 pre->act", 1, 9);
    monitor_gaps();

    // R9 early activate dropped, window unchanged
    issue(1, 3);
    issue_when_ready(0, 0);
    issue(1, 4);
    chk("R9 early act err", last_err, 1);
    chk("R9 early act row_open", row_open, 0);
    expect_gap("R9 window kept after early act", 1, 8);
    monitor_gaps();

    // R9 early read dropped, read window unchanged
    issue(1, 7);
    issue(2, 7);
    chk("R9 early rd err", last_err, 1);
    expect_gap("R9 rd window kept", 2, 8);
    monitor_gaps();
    chk("R2 reopen row", open_row, 7);

    summary();
    $finish;
  end

endmodule